// File: doc/BRIEF.md
# Serial Configuration Register Slave with Burst Access

This block lets an external host read and write a bank of 8-bit configuration registers over a four-wire serial link: an active-low select, a serial clock, a host-to-slave data line and a slave-to-host data line. The serial clock is idle low. The slave samples incoming bits on the rising clock edge and changes outgoing bits after the falling edge. All three inputs are oversampled by the system clock through a two-flop synchronizer, so the serial clock must run well below the system clock.

A frame opens when select falls. It carries a command byte, an address byte and then any number of data bytes, each sent most significant bit first. While select stays low, every further data byte goes to or comes from the next register. This allows a whole run of consecutive registers to be moved in one frame. The contents of every register are always visible to the surrounding logic on a flat output bus.

Top module: `spi_rb_slave`

## Requirements
- R1: After reset every register reads 0x00 on `cfg_regs` and `spi_miso` is 0.
- R2: A frame made of command 0x02, an address byte A and a data byte D (all MSB first, sampled on rising `spi_sclk`) stores D in register A. Register A occupies bits `cfg_regs[8*A+7 : 8*A]`.
- R3: A frame made of command 0x03 and address byte A returns register A on `spi_miso`, MSB first. The first bit is valid after the falling clock edge that follows the last address bit, and each later bit is valid after the next falling edge.
- R4: In a write frame, each data byte after the first is stored at the address one above the previous byte's address.
- R5: In a read frame, while select stays low, each further byte returns the register one above the previous one, with no new command.
- R6: The address counter wraps from 0xFF to 0x00 in both burst reads and burst writes.
- R7: Raising `spi_cs_n` in the middle of a byte discards that byte, so a partial write byte changes no register. The next frame starts again with a command byte.
- R8: `spi_miso` is 0 whenever no read data is being shifted: while select is high, during the command and address bytes, and throughout write frames.
- R9: A command byte other than 0x02 or 0x03 makes the slave ignore the rest of the frame. No register changes and `spi_miso` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low frame select from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial read data to the host |
| cfg_regs | output | 8*2^ADDR_W | All register values, register n at bits [8n+7:8n] |

## Verification
Two events can land in the same system-clock cycle. The first is the commit of a burst write byte to register 0xFF. The second is the wrap of the address counter to 0x00, which decides where the following byte goes. The bench provokes this with a burst write that starts at 0xFE and runs past the top of the map. It then compares the whole bank against an arithmetic model and reads back across the same boundary in one burst. A full 256-byte write sweep and a 256-byte read sweep that starts mid-map cross the wrap point again under a different data pattern.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_READ  = 8'h03;
    localparam logic [BYTE_W-1:0] CMD_WRITE = 8'h02;

    // Position of the frame decoder within the current transaction
    typedef enum logic [2:0] {
        PH_CMD  = 3'd0,
        PH_ADDR = 3'd1,
        PH_WR   = 3'd2,
        PH_RD   = 3'd3,
        PH_SKIP = 3'd4
    } spi_phase_e;

endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
    parameter int            WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{meta: RST_VAL, stable: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stable;

endmodule

// File: rtl/spi_rb_shifter.sv
module spi_rb_shifter
    import spi_rb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n_s,
    input  logic                sclk_s,
    input  logic                mosi_s,
    input  logic [BYTE_W-1:0]   rd_data,
    output logic [ADDR_W-1:0]   rd_addr,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [BYTE_W-1:0]   wr_data,
    output logic                miso
);

    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        spi_phase_e          phase;
        logic                is_rd;
        logic                sclk_prev;
        logic [CNT_W-1:0]    bit_cnt;
        logic [BYTE_W-1:0]   rx;
        logic [BYTE_W-1:0]   tx;
        logic [ADDR_W-1:0]   addr;
        logic                miso;
    } shift_st_t;

    shift_st_t st_d, st_q;

    logic              sclk_rise;
    logic              sclk_fall;
    logic [BYTE_W-1:0] byte_in;

    always_comb begin
        st_d      = st_q;
        sclk_rise = sclk_s & ~st_q.sclk_prev;
        sclk_fall = ~sclk_s & st_q.sclk_prev;
        byte_in   = {st_q.rx[BYTE_W-2:0], mosi_s};
        wr_en     = 1'b0;
        wr_addr   = st_q.addr;
        wr_data   = byte_in;
        // Prefetch address: the byte just decoded during the address phase,
        // otherwise the register after the current one
        rd_addr   = (st_q.phase == PH_ADDR) ? byte_in[ADDR_W-1:0]
                                            : st_q.addr + 1'b1;

        st_d.sclk_prev = sclk_s;

        if (cs_n_s) begin
            // Deselected: drop any partial byte and rearm for a command
            st_d.phase   = PH_CMD;
            st_d.is_rd   = 1'b0;
            st_d.bit_cnt = '0;
            st_d.rx      = '0;
            st_d.tx      = '0;
            st_d.miso    = 1'b0;
        end else if (sclk_rise) begin
            st_d.rx      = byte_in;
            st_d.bit_cnt = st_q.bit_cnt + 1'b1;
            if (st_q.bit_cnt == LAST_BIT) begin
                unique case (st_q.phase)
                    PH_CMD: begin
                        if (byte_in == CMD_READ) begin
                            st_d.phase = PH_ADDR;
                            st_d.is_rd = 1'b1;
                        end else if (byte_in == CMD_WRITE) begin
                            st_d.phase = PH_ADDR;
                            st_d.is_rd = 1'b0;
                        end else begin
                            st_d.phase = PH_SKIP;
                        end
                    end
                    PH_ADDR: begin
                        st_d.addr = byte_in[ADDR_W-1:0];
                        if (st_q.is_rd) begin
                            st_d.phase = PH_RD;
                            st_d.tx    = rd_data;
                        end else begin
                            st_d.phase = PH_WR;
                        end
                    end
                    PH_WR: begin
                        wr_en     = 1'b1;
                        st_d.addr = st_q.addr + 1'b1;
                    end
                    PH_RD: begin
                        st_d.addr = st_q.addr + 1'b1;
                        st_d.tx   = rd_data;
                    end
                    default: begin
                        st_d.phase = PH_SKIP;
                    end
                endcase
            end
        end else if (sclk_fall) begin
            if (st_q.phase == PH_RD) begin
                st_d.miso = st_q.tx[BYTE_W-1];
                st_d.tx   = {st_q.tx[BYTE_W-2:0], 1'b0};
            end else begin
                st_d.miso = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_CMD, is_rd: 1'b0, sclk_prev: 1'b0,
                      bit_cnt: '0, rx: '0, tx: '0, addr: '0, miso: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign miso = st_q.miso;

endmodule

// File: rtl/spi_rb_bank.sv
module spi_rb_bank
    import spi_rb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [BYTE_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [BYTE_W-1:0]           rd_data,
    output logic [BYTE_W*(1<<ADDR_W)-1:0] cfg_flat
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0][BYTE_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_addr];

    for (genvar i = 0; i < DEPTH; i++) begin : g_flat
        assign cfg_flat[i*BYTE_W +: BYTE_W] = mem_q[i];
    end

endmodule

// File: rtl/spi_rb_slave.sv
module spi_rb_slave
    import spi_rb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          spi_sclk,
    input  logic                          spi_cs_n,
    input  logic                          spi_mosi,
    output logic                          spi_miso,
    output logic [BYTE_W*(1<<ADDR_W)-1:0] cfg_regs
);

    logic [2:0]        pins_s;
    logic              cs_n_s;
    logic              sclk_s;
    logic              mosi_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [BYTE_W-1:0] rd_data;

    spi_rb_sync #(
        .WIDTH   (3),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({spi_cs_n, spi_sclk, spi_mosi}),
        .sync_o  (pins_s)
    );

    assign cs_n_s = pins_s[2];
    assign sclk_s = pins_s[1];
    assign mosi_s = pins_s[0];

    spi_rb_shifter #(
        .ADDR_W (ADDR_W)
    ) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_s  (cs_n_s),
        .sclk_s  (sclk_s),
        .mosi_s  (mosi_s),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .miso    (spi_miso)
    );

    spi_rb_bank #(
        .ADDR_W (ADDR_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .cfg_flat (cfg_regs)
    );

endmodule

// File: rtl/spi_rb_checker.sv
module spi_rb_checker
    import spi_rb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cs_n_s,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [BYTE_W-1:0]             wr_data,
    input logic                          spi_miso,
    input logic [BYTE_W*(1<<ADDR_W)-1:0] cfg_regs
);

    function automatic logic [BYTE_W-1:0] reg_at(
        input logic [BYTE_W*(1<<ADDR_W)-1:0] flat,
        input logic [ADDR_W-1:0]             a
    );
        return flat[a*BYTE_W +: BYTE_W];
    endfunction

    // R2: a write strobe from the shifter lands in the bank on the next cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (reg_at(cfg_regs, $past(wr_addr)) == $past(wr_data)));

    // R9: without a strobe the bank holds every value
    a_r9_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_regs));

    // R7: no commit is possible once select is seen high
    a_r7_no_commit_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |-> !wr_en);

    // R8: the output line returns to 0 after select is seen high
    a_r8_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (spi_miso == 1'b0));

endmodule

bind spi_rb_slave spi_rb_checker #(
    .ADDR_W (ADDR_W)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_s   (cs_n_s),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .spi_miso (spi_miso),
    .cfg_regs (cfg_regs)
);

// File: tb/tb_spi_rb_slave.sv
`timescale 1ns/1ps
module tb_spi_rb_slave;

    localparam int HALF = 6;   // system clocks per serial half period
    localparam int NREG = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic spi_miso;
    logic [8*NREG-1:0] cfg_regs;

    logic [7:0] model [NREG];
    int n_vec = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    spi_rb_slave #(.ADDR_W(8)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_sclk (spi_sclk),
        .spi_cs_n (spi_cs_n),
        .spi_mosi (spi_mosi),
        .spi_miso (spi_miso),
        .cfg_regs (cfg_regs)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic check_bank(input string tag);
        for (int a = 0; a < NREG; a++) chk(tag, cfg_regs[a*8 +: 8], model[a]);
    endtask

    task automatic xfer(input logic [7:0] b, input int nbits, output logic [7:0] r);
        r = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            spi_mosi = b[i];
            repeat (HALF) @(negedge clk);
            r[i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic sel();
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic desel();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (3 * HALF) @(negedge clk);
    endtask

    // byte that must come back as zero (R8)
    task automatic send_quiet(input logic [7:0] b, input string tag);
        logic [7:0] r;
        xfer(b, 8, r);
        chk(tag, r, 8'h00);
    endtask

    task automatic wr_burst(input logic [7:0] a0, input int n, input int mul, input int add);
        logic [7:0] a;
        sel();
        send_quiet(8'h02, "R8 cmd byte");
        send_quiet(a0, "R8 addr byte");
        a = a0;
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = 8'((k * mul + add) & 8'hFF);
            send_quiet(d, "R8 write data");
            model[a] = d;
            a = a + 8'd1;
        end
        desel();
    endtask

    task automatic rd_burst(input logic [7:0] a0, input int n, input string tag);
        logic [7:0] a;
        logic [7:0] r;
        sel();
        send_quiet(8'h03, "R8 cmd byte");
        send_quiet(a0, "R8 addr byte");
        a = a0;
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, 8, r);
            chk(tag, r, model[a]);
            a = a + 8'd1;
        end
        desel();
    endtask

    initial begin
        logic [7:0] r;
        for (int a = 0; a < NREG; a++) model[a] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        chk("R1 miso after reset", {7'd0, spi_miso}, 8'h00);
        check_bank("R1 reset value");

        // R2 single write, R3 single read
        wr_burst(8'h10, 1, 0, 8'hA5);
        check_bank("R2 single write");
        rd_burst(8'h10, 1, "R3 single read");

        // R4 burst write, R5 burst read across it
        wr_burst(8'h20, 16, 17, 3);
        check_bank("R4 burst write");
        rd_burst(8'h1E, 20, "R5 burst read");

        // R6 wrap: commit at 0xFF coincides with counter wrap
        wr_burst(8'hFE, 4, 29, 8'h5C);
        check_bank("R6 wrap write");
        rd_burst(8'hFD, 6, "R6 wrap read");

        // R7 abort inside the first data byte
        sel();
        send_quiet(8'h02, "R8 cmd byte");
        send_quiet(8'h40, "R8 addr byte");
        xfer(8'hC3, 5, r);
        desel();
        check_bank("R7 partial byte dropped");
        // R7 abort after one good byte; second byte partial
        sel();
        send_quiet(8'h02, "R8 cmd byte");
        send_quiet(8'h50, "R8 addr byte");
        send_quiet(8'h6E, "R8 write data");
        model[8'h50] = 8'h6E;
        xfer(8'h91, 3, r);
        desel();
        check_bank("R7 burst tail dropped");
        // R7 next frame decodes a fresh command
        wr_burst(8'h41, 1, 0, 8'h3C);
        check_bank("R7 fresh frame after abort");

        // R9 unknown command ignored, output silent
        sel();
        send_quiet(8'h55, "R9 bad cmd");
        send_quiet(8'h60, "R9 ignored byte");
        send_quiet(8'h77, "R9 ignored byte");
        send_quiet(8'h02, "R9 ignored byte");
        desel();
        check_bank("R9 bank unchanged");
        chk("R8 miso while deselected", {7'd0, spi_miso}, 8'h00);

        // Exhaustive sweep: write all registers, read all back from mid-map (R4 R5 R6)
        wr_burst(8'h00, NREG, 37, 11);
        check_bank("R4 full sweep write");
        rd_burst(8'h80, NREG, "R5 full sweep read");
        chk("R8 miso after read frame", {7'd0, spi_miso}, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule